// File: doc/BRIEF.md
# Queued-Command I2C Controller Engine

This block is the byte-level engine of an I2C controller. Each transfer is described by a queue of command entries. An entry holds a data byte, a read/write choice, a flag that asks for a STOP after the byte, and a flag that asks for a repeated START before it. The engine takes entries in order. It opens the bus with a START and a 7-bit target address followed by the direction bit, then moves each byte, and closes with a STOP only when an entry asks for one. Bytes received from the target are queued in a receive FIFO.

When a target does not acknowledge its address or a written byte, the engine records the reason in a sticky abort vector. It then sends a STOP and empties both queues. It accepts no new commands until the abort is cleared. The target address is taken from its input only while the engine is disabled. Addresses in the two reserved groups are refused and produce no bus activity. SCL phase timing comes from a quarter-bit tick generator. Both bus lines are open-drain: an output of 1 pulls the line low.

Top module: `i2cq_master`

## Requirements
- R1: The command FIFO holds CMD_DEPTH (16) entries and reports its fill level on `cmd_level_o`. A push into a full FIFO is dropped, and `cmd_full_o` is high while the FIFO holds CMD_DEPTH entries.
- R2: A transfer starts only while `enable_i` is high. It begins with a START and the address byte {target[6:0], rd}, where rd is the read bit of the first entry. Write bytes are sent MSB first.
- R3: An entry whose restart flag is set, or whose direction differs from the current one, is preceded by a repeated START and a fresh address byte.
- R4: An entry whose stop flag is set is followed by a STOP once its byte and acknowledge bit are done. Each STOP on the bus sets `stop_det_o`, and at that moment SCL and SDA are both released.
- R5: A read entry clocks in 8 bits, MSB first, and pushes them into the receive FIFO. The engine answers ACK (SDA low) unless the entry carries the stop flag, in which case it answers NACK.
- R6: When the command FIFO runs empty after a byte whose entry has no stop flag, SCL is held low. The transfer resumes when a new entry arrives.
- R7: `tx_empty_o` is high only when the command FIFO is empty and no byte is in the shift register. It stays low while the last popped byte is still on the bus.
- R8: When the address is not acknowledged, `abort_src_o` bit 0 is set, both FIFOs are emptied, and a STOP follows. At most one abort bit is set at a time.
- R9: When a written data byte is not acknowledged, `abort_src_o` bit 1 is set, both FIFOs are emptied, the remaining entries are lost, and a STOP follows.
- R10: A nonzero `abort_src_o` holds until a `clr_abort_i` strobe. While it is nonzero, command pushes are dropped. If a new abort and the strobe fall in the same cycle, the abort wins.
- R11: `stop_det_o` holds until a `clr_stop_i` strobe. If a new STOP and the strobe fall in the same cycle, the STOP wins.
- R12: The target address is sampled from `tar_i` only while `enable_i` is low. Changes while enabled have no effect on the address sent.
- R13: A target address whose upper four bits are 0000 or 1111 is refused. `abort_src_o` bit 2 is set, both FIFOs are emptied, and no START or STOP is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Engine enable; target address follows `tar_i` while low |
| tar_i | input | 7 | Target address |
| cmd_push_i | input | 1 | Push one command entry |
| cmd_data_i | input | 8 | Data byte of the entry |
| cmd_rd_i | input | 1 | Entry is a read |
| cmd_stop_i | input | 1 | STOP after this entry |
| cmd_restart_i | input | 1 | Repeated START before this entry |
| cmd_level_o | output | 5 | Command FIFO fill level |
| cmd_full_o | output | 1 | Command FIFO full |
| rx_pop_i | input | 1 | Pop one received byte |
| rx_data_o | output | 8 | Head of the receive FIFO |
| rx_level_o | output | 5 | Receive FIFO fill level |
| tx_empty_o | output | 1 | Queue and shift register both empty |
| stop_det_o | output | 1 | Sticky STOP-seen flag |
| clr_stop_i | input | 1 | Clear strobe for `stop_det_o` |
| abort_src_o | output | 3 | Sticky abort reason: bit0 address NACK, bit1 data NACK, bit2 reserved address |
| clr_abort_i | input | 1 | Clear strobe for `abort_src_o` |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| sda_i | input | 1 | Sampled SDA line |

## Verification
The sticky flags can receive a new event and their clear strobe in the same cycle. For example, the STOP that ends a transfer can set `stop_det_o` in the very cycle that software clears it, and likewise for an address NACK and `abort_src_o`. The bench provokes this collision by holding the clear strobe high across a whole transfer, so every cycle is a clear cycle. It then counts how many cycles the flag reads set: exactly one means the event won. Zero means the clear swallowed the event, and more than one means the clear was ignored.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  typedef struct packed {
    logic       restart;
    logic       stop;
    logic       rd;
    logic [7:0] data;
  } i2cq_cmd_t;

  localparam int ABW          = 3;
  localparam int AB_ADDR_NACK = 0;
  localparam int AB_DATA_NACK = 1;
  localparam int AB_RESERVED  = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_XFER, S_RSTART, S_STOP, S_HOLD
  } i2cq_state_t;

  function automatic logic addr_reserved(input logic [6:0] a);
    return (a[6:3] == 4'h0) || (a[6:3] == 4'hF);
  endfunction
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/i2cq_qtick.sv
module i2cq_qtick #(
  parameter int QTR = 125,
  localparam int CW = $clog2(QTR)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(QTR - 1));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (at_end)  cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cq_engine.sv
module i2cq_engine
  import i2cq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           enable,
  input  logic           blocked,
  input  logic [6:0]     tar,
  input  logic           cmd_empty,
  input  i2cq_cmd_t      cmd_head,
  output logic           cmd_pop,
  input  logic           tick,
  output logic           run,
  input  logic           sda_in,
  output logic           rx_push,
  output logic [7:0]     rx_byte,
  output logic           busy,
  output logic           abort_now,
  output logic [ABW-1:0] abort_code,
  output logic           stop_done,
  output logic           scl_low,
  output logic           sda_low
);
  i2cq_state_t state;
  logic [1:0]  q;
  logic [3:0]  bitn;
  logic [7:0]  sh;
  logic [7:0]  cur_data;
  logic        cur_rd, cur_stop, dir, nack;

  logic start_ok, hold_go, resv, byte_end, addr_nack, data_nack, wr_mode, ack_mode;
  logic last_bit;

  assign resv     = addr_reserved(tar);
  assign start_ok = (state == S_IDLE) && enable && !cmd_empty && !blocked;
  assign hold_go  = (state == S_HOLD) && !cmd_empty;
  assign cmd_pop  = start_ok || hold_go;
  assign last_bit = (bitn == 4'd8);
  assign byte_end = tick && (q == 2'd3) && last_bit &&
                    ((state == S_ADDR) || (state == S_XFER));
  assign addr_nack = byte_end && (state == S_ADDR) && nack;
  assign data_nack = byte_end && (state == S_XFER) && !cur_rd && nack;
  assign abort_now = (start_ok && resv) || addr_nack || data_nack;
  assign wr_mode   = (state == S_ADDR) || !cur_rd;
  assign ack_mode  = (state == S_XFER) && cur_rd;

  always_comb begin
    abort_code = '0;
    if (start_ok && resv) abort_code[AB_RESERVED]  = 1'b1;
    else if (addr_nack)   abort_code[AB_ADDR_NACK] = 1'b1;
    else if (data_nack)   abort_code[AB_DATA_NACK] = 1'b1;
  end

  assign rx_push   = byte_end && (state == S_XFER) && cur_rd;
  assign rx_byte   = sh;
  assign stop_done = tick && (q == 2'd3) && (state == S_STOP);
  assign run       = (state != S_IDLE) && (state != S_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      q        <= '0;
      bitn     <= '0;
      sh       <= '0;
      cur_data <= '0;
      cur_rd   <= 1'b0;
      cur_stop <= 1'b0;
      dir      <= 1'b0;
      nack     <= 1'b0;
      busy     <= 1'b0;
      scl_low  <= 1'b0;
      sda_low  <= 1'b0;
    end else begin
      if (tick) q <= q + 1'b1;
      case (state)
        S_IDLE: begin
          if (start_ok && !resv) begin
            state    <= S_START;
            dir      <= cmd_head.rd;
            cur_rd   <= cmd_head.rd;
            cur_stop <= cmd_head.stop;
            cur_data <= cmd_head.data;
            busy     <= 1'b1;
          end
        end
        S_HOLD: begin
          if (hold_go) begin
            cur_rd   <= cmd_head.rd;
            cur_stop <= cmd_head.stop;
            cur_data <= cmd_head.data;
            busy     <= 1'b1;
            if (cmd_head.restart || (cmd_head.rd != dir)) begin
              dir   <= cmd_head.rd;
              state <= S_RSTART;
            end else begin
              state <= S_XFER;
              bitn  <= '0;
              sh    <= cmd_head.data;
            end
          end
        end
        S_START: if (tick) begin
          case (q)
            2'd0: sda_low <= 1'b1;
            2'd2: scl_low <= 1'b1;
            2'd3: begin
              state <= S_ADDR;
              bitn  <= '0;
              sh    <= {tar, dir};
            end
            default: ;
          endcase
        end
        S_RSTART: if (tick) begin
          case (q)
            2'd0: sda_low <= 1'b0;
            2'd1: scl_low <= 1'b0;
            2'd2: sda_low <= 1'b1;
            default: begin
              scl_low <= 1'b1;
              state   <= S_ADDR;
              bitn    <= '0;
              sh      <= {tar, dir};
            end
          endcase
        end
        S_ADDR, S_XFER: if (tick) begin
          case (q)
            2'd0: begin
              if (!last_bit) sda_low <= wr_mode ? ~sh[7] : 1'b0;
              else           sda_low <= ack_mode ? ~cur_stop : 1'b0;
            end
            2'd1: scl_low <= 1'b0;
            2'd2: begin
              if (!last_bit) sh   <= {sh[6:0], sda_in};
              else           nack <= sda_in;
            end
            default: begin
              scl_low <= 1'b1;
              if (!last_bit) begin
                bitn <= bitn + 1'b1;
              end else if (state == S_ADDR) begin
                if (nack) begin
                  busy  <= 1'b0;
                  state <= S_STOP;
                end else begin
                  state <= S_XFER;
                  bitn  <= '0;
                  sh    <= cur_data;
                end
              end else begin
                busy <= 1'b0;
                if (data_nack || cur_stop) state <= S_STOP;
                else                       state <= S_HOLD;
              end
            end
          endcase
        end
        S_STOP: if (tick) begin
          case (q)
            2'd0: sda_low <= 1'b1;
            2'd1: scl_low <= 1'b0;
            2'd2: sda_low <= 1'b0;
            default: state <= S_IDLE;
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cq_master.sv
module i2cq_master
  import i2cq_pkg::*;
#(
  parameter int CMD_DEPTH  = 16,
  parameter int RX_DEPTH   = 16,
  parameter int QTR_CYCLES = 125,
  localparam int CMD_LW = $clog2(CMD_DEPTH + 1),
  localparam int RX_LW  = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic [6:0]        tar_i,
  input  logic              cmd_push_i,
  input  logic [7:0]        cmd_data_i,
  input  logic              cmd_rd_i,
  input  logic              cmd_stop_i,
  input  logic              cmd_restart_i,
  output logic [CMD_LW-1:0] cmd_level_o,
  output logic              cmd_full_o,
  input  logic              rx_pop_i,
  output logic [7:0]        rx_data_o,
  output logic [RX_LW-1:0]  rx_level_o,
  output logic              tx_empty_o,
  output logic              stop_det_o,
  input  logic              clr_stop_i,
  output logic [ABW-1:0]    abort_src_o,
  input  logic              clr_abort_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  localparam int CW = $bits(i2cq_cmd_t);

  i2cq_cmd_t      push_entry, head;
  logic           cmd_empty, cmd_pop, rx_empty, rx_full;
  logic           tick, run, rx_push, busy, abort_now, stop_done;
  logic [7:0]     rx_byte;
  logic [ABW-1:0] abort_code;
  logic [6:0]     tar_q;
  logic           blocked;

  assign blocked    = |abort_src_o;
  assign push_entry = '{restart: cmd_restart_i, stop: cmd_stop_i,
                        rd: cmd_rd_i, data: cmd_data_i};

  always_ff @(posedge clk) begin
    if (rst)            tar_q <= '0;
    else if (!enable_i) tar_q <= tar_i;
  end

  i2cq_fifo #(.WIDTH(CW), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk(clk), .rst(rst), .flush(abort_now),
    .push(cmd_push_i && !blocked), .wdata(push_entry),
    .pop(cmd_pop), .rdata(head),
    .level(cmd_level_o), .full(cmd_full_o), .empty(cmd_empty)
  );

  i2cq_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(abort_now),
    .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop_i), .rdata(rx_data_o),
    .level(rx_level_o), .full(rx_full), .empty(rx_empty)
  );

  i2cq_qtick #(.QTR(QTR_CYCLES)) u_qtick (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  i2cq_engine u_engine (
    .clk(clk), .rst(rst), .enable(enable_i), .blocked(blocked),
    .tar(tar_q), .cmd_empty(cmd_empty), .cmd_head(head), .cmd_pop(cmd_pop),
    .tick(tick), .run(run), .sda_in(sda_i),
    .rx_push(rx_push), .rx_byte(rx_byte), .busy(busy),
    .abort_now(abort_now), .abort_code(abort_code), .stop_done(stop_done),
    .scl_low(scl_oe_o), .sda_low(sda_oe_o)
  );

  assign tx_empty_o = cmd_empty && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_src_o <= '0;
      stop_det_o  <= 1'b0;
    end else begin
      if (abort_now)        abort_src_o <= abort_src_o | abort_code;
      else if (clr_abort_i) abort_src_o <= '0;
      if (stop_done)        stop_det_o <= 1'b1;
      else if (clr_stop_i)  stop_det_o <= 1'b0;
    end
  end

  logic unused_ok;
  assign unused_ok = rx_empty ^ rx_full;
endmodule

// File: rtl/i2cq_master_chk.sv
module i2cq_master_chk #(
  parameter int CLW = 5,
  parameter int RLW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic [CLW-1:0] cmd_level,
  input logic [RLW-1:0] rx_level,
  input logic           tx_empty,
  input logic           stop_det,
  input logic           clr_stop,
  input logic [2:0]     abort_src,
  input logic           clr_abort,
  input logic           scl_oe,
  input logic           sda_oe
);
  AST_ABORT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(abort_src)); // R8

  AST_ABORT_FLUSHES: assert property (@(posedge clk) disable iff (rst)
    $rose(|abort_src) |-> (cmd_level == '0 && rx_level == '0)); // R9

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((|abort_src) && !clr_abort) |=> (abort_src == $past(abort_src))); // R10

  AST_NO_PUSH_ABORTED: assert property (@(posedge clk) disable iff (rst)
    (|abort_src) |=> (cmd_level <= $past(cmd_level))); // R10

  AST_TX_EMPTY_QUEUE: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> (cmd_level == '0)); // R7

  AST_STOP_RELEASED: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_det) |-> (!scl_oe && !sda_oe)); // R4

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !clr_stop) |=> stop_det); // R11
endmodule

bind i2cq_master i2cq_master_chk #(.CLW(CMD_LW), .RLW(RX_LW)) u_chk (
  .clk(clk), .rst(rst), .cmd_level(cmd_level_o), .rx_level(rx_level_o),
  .tx_empty(tx_empty_o), .stop_det(stop_det_o), .clr_stop(clr_stop_i),
  .abort_src(abort_src_o), .clr_abort(clr_abort_i),
  .scl_oe(scl_oe_o), .sda_oe(sda_oe_o)
);

// File: tb/i2cq_master_tb_top.sv
module i2cq_master_tb_top;
  localparam logic [6:0] TGT = 7'h2C;

  logic clk = 1'b0, rst = 1'b1;
  logic enable_i = 1'b0;
  logic [6:0] tar_i = TGT;
  logic cmd_push_i = 1'b0, cmd_rd_i = 1'b0, cmd_stop_i = 1'b0, cmd_restart_i = 1'b0;
  logic [7:0] cmd_data_i = '0;
  logic rx_pop_i = 1'b0, clr_stop_i = 1'b0, clr_abort_i = 1'b0;
  logic [4:0] cmd_level_o, rx_level_o;
  logic cmd_full_o, tx_empty_o, stop_det_o, scl_oe_o, sda_oe_o;
  logic [7:0] rx_data_o;
  logic [2:0] abort_src_o;

  logic t_drv = 1'b0;
  wire  scl = ~scl_oe_o;
  wire  sda = ~(sda_oe_o | t_drv);

  always #10 clk = ~clk;

  i2cq_master #(.CMD_DEPTH(16), .RX_DEPTH(16), .QTR_CYCLES(4)) dut_i (
    .clk(clk), .rst(rst), .enable_i(enable_i), .tar_i(tar_i),
    .cmd_push_i(cmd_push_i), .cmd_data_i(cmd_data_i), .cmd_rd_i(cmd_rd_i),
    .cmd_stop_i(cmd_stop_i), .cmd_restart_i(cmd_restart_i),
    .cmd_level_o(cmd_level_o), .cmd_full_o(cmd_full_o),
    .rx_pop_i(rx_pop_i), .rx_data_o(rx_data_o), .rx_level_o(rx_level_o),
    .tx_empty_o(tx_empty_o), .stop_det_o(stop_det_o), .clr_stop_i(clr_stop_i),
    .abort_src_o(abort_src_o), .clr_abort_i(clr_abort_i),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .sda_i(sda)
  );

  // ---------------- target model ----------------
  int   t_state = 0;   // 0 idle, 1 address, 2 write, 3 read
  int   t_bit = 0;
  logic [7:0] t_sh = '0, t_rbyte = '0;
  logic t_rw = 1'b0, t_ack_addr = 1'b0, t_mack = 1'b0;
  logic [7:0] wr_log [64];
  int   wr_cnt = 0, rd_idx = 0, nack_at = -1, start_cnt = 0;

  function automatic logic [7:0] rpat(input int i);
    return 8'hC3 ^ 8'(i * 29);
  endfunction

  always @(negedge sda) if (scl === 1'b1) begin
    t_state = 1; t_bit = 0; t_drv = 1'b0; start_cnt++;
  end
  always @(posedge sda) if (scl === 1'b1) begin
    t_state = 0; t_drv = 1'b0;
  end
  always @(posedge scl) if (t_state != 0) begin
    if (t_bit < 8) t_sh = {t_sh[6:0], sda};
    else           t_mack = sda;
    t_bit++;
  end
  always @(negedge scl) if (t_state != 0) begin
    if (t_bit == 8) begin
      if (t_state == 1) begin
        t_ack_addr = (t_sh[7:1] == TGT);
        t_rw  = t_sh[0];
        t_drv = t_ack_addr;
      end else if (t_state == 2) begin
        if (wr_cnt < 64) wr_log[wr_cnt] = t_sh;
        t_drv = (wr_cnt != nack_at);
        wr_cnt++;
      end else t_drv = 1'b0;
    end else if (t_bit == 9) begin
      t_bit = 0; t_drv = 1'b0;
      if (t_state == 1) begin
        if (!t_ack_addr) t_state = 0;
        else if (t_rw) begin
          t_state = 3; t_rbyte = rpat(rd_idx); rd_idx++; t_drv = ~t_rbyte[7];
        end else t_state = 2;
      end else if (t_state == 3) begin
        if (t_mack) t_state = 0;
        else begin t_rbyte = rpat(rd_idx); rd_idx++; t_drv = ~t_rbyte[7]; end
      end
    end else if (t_state == 3) t_drv = ~t_rbyte[7 - t_bit];
  end

  // ---------------- bench helpers ----------------
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic rd, input logic st, input logic rs);
    @(negedge clk);
    cmd_push_i = 1'b1; cmd_data_i = d; cmd_rd_i = rd; cmd_stop_i = st; cmd_restart_i = rs;
    @(negedge clk);
    cmd_push_i = 1'b0; cmd_stop_i = 1'b0; cmd_restart_i = 1'b0; cmd_rd_i = 1'b0;
  endtask

  task automatic setup(input logic [6:0] a);
    @(negedge clk); enable_i = 1'b0; tar_i = a;
    @(negedge clk); @(negedge clk);
    wr_cnt = 0; rd_idx = 0; nack_at = -1; start_cnt = 0;
  endtask

  task automatic go();
    @(negedge clk); enable_i = 1'b1;
  endtask

  task automatic wait_stop(input int maxc, output bit seen);
    seen = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (stop_det_o) begin seen = 1; break; end
    end
  endtask

  task automatic clr_flags();
    @(negedge clk); clr_stop_i = 1'b1; clr_abort_i = 1'b1;
    @(negedge clk); clr_stop_i = 1'b0; clr_abort_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pop_rx(output logic [7:0] d);
    @(negedge clk); d = rx_data_o; rx_pop_i = 1'b1;
    @(negedge clk); rx_pop_i = 1'b0;
  endtask

  initial begin : watchdog
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit seen;
    logic [7:0] d;
    int cnt;
    idle(3);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(cmd_level_o == 0 && rx_level_o == 0 && tx_empty_o && !stop_det_o && abort_src_o == 0
        && !scl_oe_o && !sda_oe_o, "reset", {cmd_level_o, abort_src_o}, 0);

    // R1: fill 16 entries, 17th dropped; R2: nothing starts while disabled
    setup(TGT);
    for (int i = 0; i < 17; i++) push(8'(i * 7 + 1), 1'b0, i == 15, 1'b0);
    chk(cmd_level_o == 16 && cmd_full_o, "R1 level/full", cmd_level_o, 16);
    idle(200);
    chk(start_cnt == 0 && cmd_level_o == 16, "R2 no start while disabled", start_cnt, 0);
    go();
    wait_stop(6000, seen);
    chk(seen, "R4 stop after flagged entry", seen, 1);
    chk(wr_cnt == 16 && start_cnt == 1, "R2 one start, 16 bytes", wr_cnt, 16);
    for (int i = 0; i < 16; i++)
      chk(wr_log[i] == 8'(i * 7 + 1), "R2 byte MSB-first", wr_log[i], 8'(i * 7 + 1));
    chk(tx_empty_o && abort_src_o == 0, "R7 empty at end", tx_empty_o, 1);
    clr_flags();
    chk(!stop_det_o, "R11 clear", stop_det_o, 0);

    // R7: byte in flight keeps tx_empty low
    setup(TGT);
    push(8'hA5, 1'b0, 1'b1, 1'b0);
    go(); idle(20);
    chk(cmd_level_o == 0 && !tx_empty_o, "R7 busy shift", tx_empty_o, 0);
    wait_stop(2000, seen);
    chk(seen && tx_empty_o && wr_log[0] == 8'hA5, "R7 done", wr_log[0], 8'hA5);
    clr_flags();

    // R5: read three bytes, last NACKed
    setup(TGT);
    push(8'h00, 1'b1, 1'b0, 1'b0);
    push(8'h00, 1'b1, 1'b0, 1'b0);
    push(8'h00, 1'b1, 1'b1, 1'b0);
    go(); wait_stop(3000, seen);
    chk(seen && rx_level_o == 3, "R5 rx level", rx_level_o, 3);
    chk(t_mack == 1'b1 && rd_idx == 3, "R5 final NACK", t_mack, 1);
    for (int i = 0; i < 3; i++) begin
      pop_rx(d);
      chk(d == rpat(i), "R5 rx data", d, rpat(i));
    end
    clr_flags();

    // R3: restart flag on same direction, then direction change without flag
    setup(TGT);
    push(8'h11, 1'b0, 1'b0, 1'b0);
    push(8'h22, 1'b0, 1'b0, 1'b1);
    push(8'h00, 1'b1, 1'b1, 1'b0);
    go(); wait_stop(3000, seen);
    chk(seen && start_cnt == 3, "R3 repeated starts", start_cnt, 3);
    chk(wr_cnt == 2 && wr_log[0] == 8'h11 && wr_log[1] == 8'h22, "R3 write bytes", wr_log[1], 8'h22);
    pop_rx(d);
    chk(d == rpat(0), "R3 read after restart", d, rpat(0));
    clr_flags();

    // R6: hold SCL low while queue empty
    setup(TGT);
    push(8'h3C, 1'b0, 1'b0, 1'b0);
    go(); idle(600);
    chk(scl_oe_o && !stop_det_o && tx_empty_o, "R6 hold scl low", scl_oe_o, 1);
    push(8'h4D, 1'b0, 1'b1, 1'b0);
    wait_stop(2000, seen);
    chk(seen && wr_cnt == 2 && wr_log[1] == 8'h4D && start_cnt == 1, "R6 resume", wr_cnt, 2);
    clr_flags();

    // R9: data NACK on second byte; third entry flushed
    setup(TGT);
    nack_at = 1;
    push(8'h01, 1'b0, 1'b0, 1'b0);
    push(8'h02, 1'b0, 1'b0, 1'b0);
    push(8'h03, 1'b0, 1'b1, 1'b0);
    go(); wait_stop(3000, seen);
    chk(seen && abort_src_o == 3'b010, "R9 data nack code", abort_src_o, 2);
    chk(cmd_level_o == 0 && wr_cnt == 2, "R9 flushed", wr_cnt, 2);
    // R10: pushes dropped while aborted
    push(8'h77, 1'b0, 1'b1, 1'b0);
    chk(cmd_level_o == 0 && abort_src_o == 3'b010, "R10 push dropped", cmd_level_o, 0);
    clr_flags();
    chk(abort_src_o == 0, "R10 cleared", abort_src_o, 0);

    // R12: address change while enabled ignored
    setup(TGT);
    go();
    @(negedge clk); tar_i = 7'h33;
    push(8'h5E, 1'b0, 1'b1, 1'b0);
    wait_stop(2000, seen);
    chk(seen && abort_src_o == 0 && wr_log[0] == 8'h5E, "R12 old address used", abort_src_o, 0);
    clr_flags();

    // R11 / R10: event and clear in same cycle -> event wins for one cycle
    setup(TGT);
    @(negedge clk); clr_stop_i = 1'b1;
    push(8'h66, 1'b0, 1'b1, 1'b0);
    go(); cnt = 0;
    for (int i = 0; i < 1500; i++) begin @(negedge clk); if (stop_det_o) cnt++; end
    clr_stop_i = 1'b0;
    chk(cnt == 1, "R11 set wins over clear", cnt, 1);
    setup(7'h45);
    @(negedge clk); clr_abort_i = 1'b1;
    push(8'h66, 1'b0, 1'b1, 1'b0);
    go(); cnt = 0;
    for (int i = 0; i < 1500; i++) begin @(negedge clk); if (abort_src_o != 0) cnt++; end
    clr_abort_i = 1'b0;
    chk(cnt == 1, "R10 set wins over clear", cnt, 1);
    clr_flags();

    // R8 / R13: sweep every address
    for (int a = 0; a < 128; a++) begin
      bit rsv;
      rsv = (a[6:3] == 4'h0) || (a[6:3] == 4'hF);
      setup(7'(a));
      push(8'(a ^ 8'h96), 1'b0, 1'b1, 1'b0);
      go();
      wait_stop(rsv ? 300 : 1500, seen);
      if (rsv) begin
        chk(!seen && abort_src_o == 3'b100 && start_cnt == 0 && cmd_level_o == 0,
            "R13 reserved refused", abort_src_o, 4);
      end else if (7'(a) == TGT) begin
        chk(seen && abort_src_o == 0 && wr_log[0] == 8'(a ^ 8'h96), "R2 sweep target", abort_src_o, 0);
      end else begin
        chk(seen && abort_src_o == 3'b001 && cmd_level_o == 0 && wr_cnt == 0,
            "R8 address nack", abort_src_o, 1);
      end
      clr_flags();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule